// File: doc/BRIEF.md
# Seven-Pin GPIO Register Bank

This block is a small bank of general-purpose I/O pins controlled through a flat register interface. A write strobe, a 7-bit address and a pin-wide data word update one register per cycle. Read data is a combinational function of the address. Each pin has its own configuration bits:

- direction
- output style (push-pull or open-drain)
- output value
- output inversion and input inversion
- a sticky one-shot capture mode

Schmitt, pull-up, pull-down and drive-strength bits are held here and exported to the pad ring as plain control lines.

The pad side gives, per pin, a value, an output enable and an open-drain qualifier, and takes the raw pad sample in. When the GPIO function is enabled, every register can be returned to zero in two ways. One is a dedicated reset-command input. The other is a one-byte reset opcode sent over a chip-select-framed serial line. The serial inputs are synchronised into the system clock, so the serial clock must be several times slower than that clock.

All interfaces are plain control and status pins. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `gpio_bank`

## Requirements
- R1: After `rst_n` is released, every register reads 0 and `pad_oe`, `pad_out` and `pad_od` are all 0 (with `pad_in` held at 0).
- R2: The read/write configuration registers sit at these addresses, and a written value reads back unchanged: 0x00 direction (1 = output), 0x01 output style (1 = push-pull, 0 = open-drain), 0x02 output value, 0x03 Schmitt, 0x04 pull-up, 0x05 pull-down, 0x06 drive strength, 0x08 input inversion, 0x09 output inversion and 0x0C one-shot enable.
- R3: Any address other than 0x00–0x09 and 0x0C reads 0, and a write to it changes no register.
- R4: Per pin, let v = output value XOR output inversion. With push-pull selected, `pad_out` = v and `pad_oe` = direction. With open-drain selected, `pad_out` = 0 and `pad_oe` = direction AND NOT v. `pad_od` = direction AND NOT style. An input pin never has `pad_oe` set.
- R5: The output inversion bit flips the value a pin drives, both in push-pull and in open-drain mode.
- R6: For a pin not in one-shot mode, bit n of register 0x07 equals `pad_in[n]` XOR input inversion[n], registered one clock after the sample. Writes to that bit of 0x07 have no effect.
- R7: For a pin in one-shot mode, bit n of 0x07 is set once the inverted sample is 1. It then stays 1 until a write to 0x07 with bit n = 1 while the sample is 0. A clear written while the sample is still 1 leaves the bit at 1.
- R8: A one-cycle pulse on `gpio_rst_cmd` while `gpio_en` = 1 clears every register at the next clock edge. The same pulse with `gpio_en` = 0 changes nothing.
- R9: With `gpio_en` = 1, the serial reset fires (clearing all registers) only when all three hold: `ser_cs_n` falls; exactly 8 bits are shifted MSB first on rising `ser_sclk`; `ser_cs_n` rises with those bits equal to `RST_OPCODE`. A frame of 7 or 9 bits, a different code, or `gpio_en` = 0 leaves the registers unchanged.
- R10: `pad_schmitt`, `pad_pull_up`, `pad_pull_dn` and `pad_drv_hi` equal registers 0x03, 0x04, 0x05 and 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| gpio_en | input | 1 | GPIO function enable; gates both reset commands |
| gpio_rst_cmd | input | 1 | Dedicated GPIO reset command pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | NPIN | Write data |
| reg_rdata | output | NPIN | Combinational read data |
| ser_cs_n | input | 1 | Serial chip select, active low |
| ser_sclk | input | 1 | Serial clock |
| ser_mosi | input | 1 | Serial data in |
| pad_in | input | NPIN | Raw pad samples |
| pad_out | output | NPIN | Value to drive on each pad |
| pad_oe | output | NPIN | Per-pad output enable |
| pad_od | output | NPIN | Per-pad open-drain qualifier |
| pad_schmitt | output | NPIN | Schmitt-trigger enables |
| pad_pull_up | output | NPIN | Pull-up enables |
| pad_pull_dn | output | NPIN | Pull-down enables |
| pad_drv_hi | output | NPIN | Strong-drive selects |

## Verification
The bench builds the block with its default seven pins, a two-stage serial synchroniser and a reset opcode of 0x5F, which reads differently when its bit order is reversed. At seven pins every register value is a 7-bit word, so each configuration register is swept through all 128 values. The pin datapath is swept over 128 mixed patterns of direction, style, value and inversion. The inverted input sample is swept over all 128 pad values under three inversion masks. The serial reset is exercised with a correct frame and with each way a frame can be wrong: short, long, wrong code, reversed bit order, and function disabled.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 7;

  localparam logic [ADDR_W-1:0] A_DIR   = 7'h00;
  localparam logic [ADDR_W-1:0] A_STYLE = 7'h01;
  localparam logic [ADDR_W-1:0] A_VAL   = 7'h02;
  localparam logic [ADDR_W-1:0] A_SCHM  = 7'h03;
  localparam logic [ADDR_W-1:0] A_PUP   = 7'h04;
  localparam logic [ADDR_W-1:0] A_PDN   = 7'h05;
  localparam logic [ADDR_W-1:0] A_DRV   = 7'h06;
  localparam logic [ADDR_W-1:0] A_SAMP  = 7'h07;
  localparam logic [ADDR_W-1:0] A_IINV  = 7'h08;
  localparam logic [ADDR_W-1:0] A_OINV  = 7'h09;
  localparam logic [ADDR_W-1:0] A_ONCE  = 7'h0C;

  function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
    return (a <= A_OINV) || (a == A_ONCE);
  endfunction
endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int unsigned W = 7,
  parameter logic [6:0]  ADDR = 7'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [6:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      q <= '0;
    else if (clr)                    q <= '0;
    else if (we && (addr == ADDR))   q <= wdata;
  end
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic dir,
  input  logic push_pull,
  input  logic val,
  input  logic out_inv,
  input  logic in_inv,
  input  logic once_en,
  input  logic clr_wr,
  input  logic pin_in,
  output logic pin_out,
  output logic pin_oe,
  output logic pin_od,
  output logic samp_q
);
  logic drv_val;
  logic samp;

  assign drv_val = val ^ out_inv;
  assign pin_out = push_pull & drv_val;
  assign pin_oe  = dir & (push_pull | ~drv_val);
  assign pin_od  = dir & ~push_pull;
  assign samp    = pin_in ^ in_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       samp_q <= 1'b0;
    else if (clr)     samp_q <= 1'b0;
    else if (once_en) samp_q <= (samp_q & ~clr_wr) | samp;
    else              samp_q <= samp;
  end

  AST_ONCE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (once_en && samp_q && !clr_wr && !clr) |=> samp_q); // R7
  AST_LIVE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!once_en && !clr) |=> (samp_q == $past(samp))); // R6
endmodule

// File: rtl/gpio_ser_rst.sv
module gpio_ser_rst #(
  parameter int unsigned SYNC = 2,
  parameter logic [7:0]  RST_OPCODE = 8'h5F
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic fire
);
  localparam int unsigned CNT_W   = 4;
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(8);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(9);

  logic [SYNC-1:0] cs_s, ck_s, d_s;
  logic            cs_prev, ck_prev;
  logic [7:0]      shreg;
  logic [CNT_W-1:0] cnt;
  logic            cs_now, ck_now, d_now, ck_rise, cs_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s <= '1; ck_s <= '0; d_s <= '0;
      cs_prev <= 1'b1; ck_prev <= 1'b0;
    end else begin
      cs_s <= {cs_s[SYNC-2:0], cs_n};
      ck_s <= {ck_s[SYNC-2:0], sclk};
      d_s  <= {d_s[SYNC-2:0], mosi};
      cs_prev <= cs_now;
      ck_prev <= ck_now;
    end
  end

  assign cs_now  = cs_s[SYNC-1];
  assign ck_now  = ck_s[SYNC-1];
  assign d_now   = d_s[SYNC-1];
  assign ck_rise = ck_now & ~ck_prev & ~cs_now;
  assign cs_rise = cs_now & ~cs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; shreg <= '0;
    end else if (cs_now) begin
      cnt <= '0;
    end else if (ck_rise) begin
      shreg <= {shreg[6:0], d_now};
      cnt   <= (cnt == CNT_OVER) ? CNT_OVER : cnt + 1'b1;
    end
  end

  assign fire = cs_rise && (cnt == CNT_BYTE) && (shreg == RST_OPCODE);

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cs_now |=> (cnt == '0)); // R9
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned NPIN = 7,
  parameter int unsigned SYNC = 2,
  parameter logic [7:0]  RST_OPCODE = 8'h5F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gpio_en,
  input  logic            gpio_rst_cmd,
  input  logic            reg_we,
  input  logic [6:0]      reg_addr,
  input  logic [NPIN-1:0] reg_wdata,
  output logic [NPIN-1:0] reg_rdata,
  input  logic            ser_cs_n,
  input  logic            ser_sclk,
  input  logic            ser_mosi,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_od,
  output logic [NPIN-1:0] pad_schmitt,
  output logic [NPIN-1:0] pad_pull_up,
  output logic [NPIN-1:0] pad_pull_dn,
  output logic [NPIN-1:0] pad_drv_hi
);
  import gpio_bank_pkg::*;

  localparam int unsigned NCFG = 10;
  localparam logic [6:0] CFG_ADDR [NCFG] = '{A_DIR, A_STYLE, A_VAL, A_SCHM, A_PUP,
                                             A_PDN, A_DRV, A_IINV, A_OINV, A_ONCE};

  logic            ser_fire, grst;
  logic [NPIN-1:0] cfg [NCFG];
  logic [NPIN-1:0] samp_q, clr_wr;

  gpio_ser_rst #(.SYNC(SYNC), .RST_OPCODE(RST_OPCODE)) u_ser (
    .clk(clk), .rst_n(rst_n), .cs_n(ser_cs_n), .sclk(ser_sclk),
    .mosi(ser_mosi), .fire(ser_fire));

  assign grst = gpio_en & (gpio_rst_cmd | ser_fire);

  for (genvar r = 0; r < NCFG; r++) begin : g_cfg
    gpio_cfg_reg #(.W(NPIN), .ADDR(CFG_ADDR[r])) u_reg (
      .clk(clk), .rst_n(rst_n), .clr(grst), .we(reg_we),
      .addr(reg_addr), .wdata(reg_wdata), .q(cfg[r]));
  end

  assign clr_wr = (reg_we && reg_addr == A_SAMP) ? reg_wdata : '0;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gpio_pin_slice u_pin (
      .clk(clk), .rst_n(rst_n), .clr(grst),
      .dir(cfg[0][i]), .push_pull(cfg[1][i]), .val(cfg[2][i]),
      .out_inv(cfg[8][i]), .in_inv(cfg[7][i]), .once_en(cfg[9][i]),
      .clr_wr(clr_wr[i]), .pin_in(pad_in[i]),
      .pin_out(pad_out[i]), .pin_oe(pad_oe[i]), .pin_od(pad_od[i]),
      .samp_q(samp_q[i]));
  end

  assign pad_schmitt = cfg[3];
  assign pad_pull_up = cfg[4];
  assign pad_pull_dn = cfg[5];
  assign pad_drv_hi  = cfg[6];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_SAMP) reg_rdata = samp_q;
    for (int r = 0; r < NCFG; r++)
      if (reg_addr == CFG_ADDR[r]) reg_rdata = cfg[r];
  end

  logic [NCFG*NPIN-1:0] cfg_flat;
  always_comb
    for (int r = 0; r < NCFG; r++) cfg_flat[r*NPIN +: NPIN] = cfg[r];

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !addr_mapped(reg_addr) && !grst) |=> $stable(cfg_flat)); // R3
  AST_CMD_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_en && gpio_rst_cmd) |=> (cfg_flat == '0 && samp_q == '0)); // R8
  AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_DIR && !grst) |=> ((pad_oe & ~$past(reg_wdata)) == '0)); // R4
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam logic [7:0] OPC = 8'h5F;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, gpio_en, gpio_rst_cmd, reg_we, ser_cs_n, ser_sclk, ser_mosi;
  logic [6:0] reg_addr, reg_wdata, reg_rdata, pad_in;
  logic [6:0] pad_out, pad_oe, pad_od, pad_schmitt, pad_pull_up, pad_pull_dn, pad_drv_hi;

  int checks = 0;
  int failures = 0;

  gpio_bank #(.NPIN(7), .SYNC(2), .RST_OPCODE(OPC)) u_dut (
    .clk(clk), .rst_n(rst_n), .gpio_en(gpio_en), .gpio_rst_cmd(gpio_rst_cmd),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ser_cs_n(ser_cs_n), .ser_sclk(ser_sclk), .ser_mosi(ser_mosi), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_schmitt(pad_schmitt),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn), .pad_drv_hi(pad_drv_hi));

  task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [6:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [6:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ser_send(input logic [15:0] bits, input int n);
    ser_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      ser_mosi = bits[i]; ser_sclk = 1'b0;
      repeat (4) @(negedge clk);
      ser_sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    ser_sclk = 1'b0;
    repeat (4) @(negedge clk);
    ser_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [6:0] d, e;
    logic [6:0] cfg_addrs [10] = '{7'h00, 7'h01, 7'h02, 7'h03, 7'h04, 7'h05, 7'h06, 7'h08, 7'h09, 7'h0C};
    logic [6:0] bad_addrs [5]  = '{7'h0A, 7'h0B, 7'h0D, 7'h10, 7'h7F};
    logic [6:0] inv_masks [3]  = '{7'h00, 7'h55, 7'h7F};
    rst_n = 1'b0; gpio_en = 1'b1; gpio_rst_cmd = 1'b0; reg_we = 1'b0;
    reg_addr = '0; reg_wdata = '0; ser_cs_n = 1'b1; ser_sclk = 1'b0; ser_mosi = 1'b0;
    pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 13; a++) begin
      rd(7'(a), d); chk("R1 reset readback", d, 7'h00);
    end
    chk("R1 reset pad_oe", pad_oe, 7'h00);
    chk("R1 reset pad_out", pad_out, 7'h00);
    chk("R1 reset pad_od", pad_od, 7'h00);

    // R2 / R10 exhaustive register sweep
    for (int r = 0; r < 10; r++) begin
      for (int v = 0; v < 128; v++) begin
        wr(cfg_addrs[r], 7'(v));
        rd(cfg_addrs[r], d);
        chk("R2 readback", d, 7'(v));
        if (cfg_addrs[r] == 7'h03) chk("R10 schmitt", pad_schmitt, 7'(v));
        if (cfg_addrs[r] == 7'h04) chk("R10 pull up", pad_pull_up, 7'(v));
        if (cfg_addrs[r] == 7'h05) chk("R10 pull down", pad_pull_dn, 7'(v));
        if (cfg_addrs[r] == 7'h06) chk("R10 drive", pad_drv_hi, 7'(v));
      end
      wr(cfg_addrs[r], 7'h00);
    end

    // R3 unmapped addresses
    wr(7'h00, 7'h2A); wr(7'h0C, 7'h00);
    for (int k = 0; k < 5; k++) begin
      wr(bad_addrs[k], 7'h7F);
      rd(bad_addrs[k], d); chk("R3 unmapped reads zero", d, 7'h00);
      rd(7'h00, d);        chk("R3 direction untouched", d, 7'h2A);
      rd(7'h0C, d);        chk("R3 one-shot untouched", d, 7'h00);
    end

    // R4 / R5 output datapath sweep
    for (int v = 0; v < 128; v++) begin
      logic [6:0] dv, mv, wv, ov, pv;
      dv = 7'(v); mv = 7'((v * 5) & 127); wv = 7'((v * 11) & 127); ov = 7'((v * 13) & 127);
      wr(7'h00, dv); wr(7'h01, mv); wr(7'h02, wv); wr(7'h09, ov);
      pv = wv ^ ov;
      chk("R4 R5 pad_out", pad_out, mv & pv);
      chk("R4 R5 pad_oe", pad_oe, dv & (mv | ~pv));
      chk("R4 pad_od", pad_od, dv & ~mv);
    end
    wr(7'h00, 7'h00); wr(7'h09, 7'h00);

    // R6 live sample with inversion, writes ignored
    for (int m = 0; m < 3; m++) begin
      wr(7'h08, inv_masks[m]);
      for (int v = 0; v < 128; v++) begin
        pad_in = 7'(v);
        @(negedge clk);
        rd(7'h07, d); chk("R6 sample xor inversion", d, 7'(v) ^ inv_masks[m]);
      end
    end
    wr(7'h08, 7'h00);
    pad_in = 7'h00;
    wr(7'h07, 7'h7F);
    rd(7'h07, d); chk("R6 write ignored", d, 7'h00);

    // R7 one-shot capture
    wr(7'h0C, 7'h7F);
    pad_in = 7'h15; @(negedge clk);
    rd(7'h07, d); chk("R7 captured", d, 7'h15);
    pad_in = 7'h00; @(negedge clk);
    rd(7'h07, d); chk("R7 sticky after pin low", d, 7'h15);
    wr(7'h07, 7'h05);
    rd(7'h07, d); chk("R7 write-one clears", d, 7'h10);
    pad_in = 7'h10;
    wr(7'h07, 7'h10);
    rd(7'h07, d); chk("R7 set wins over clear", d, 7'h10);
    pad_in = 7'h00;
    wr(7'h07, 7'h10);
    rd(7'h07, d); chk("R7 cleared", d, 7'h00);
    wr(7'h0C, 7'h0F);
    pad_in = 7'h7F; @(negedge clk);
    pad_in = 7'h00; @(negedge clk);
    rd(7'h07, d); chk("R7 mixed pins", d, 7'h0F);
    wr(7'h0C, 7'h00);
    @(negedge clk);

    // R8 dedicated reset command
    wr(7'h00, 7'h7F); wr(7'h0C, 7'h33);
    gpio_rst_cmd = 1'b1; @(negedge clk); gpio_rst_cmd = 1'b0;
    rd(7'h00, d); chk("R8 cmd clears direction", d, 7'h00);
    rd(7'h0C, d); chk("R8 cmd clears one-shot", d, 7'h00);
    wr(7'h00, 7'h7F);
    gpio_en = 1'b0;
    gpio_rst_cmd = 1'b1; @(negedge clk); gpio_rst_cmd = 1'b0;
    rd(7'h00, d); chk("R8 cmd ignored when disabled", d, 7'h7F);
    gpio_en = 1'b1;

    // R9 serial reset frames
    e = 7'h7F;
    ser_send({8'h00, OPC}, 7);
    rd(7'h00, d); chk("R9 seven bits rejected", d, e);
    ser_send({7'h00, OPC, 1'b0}, 9);
    rd(7'h00, d); chk("R9 nine bits rejected", d, e);
    ser_send({8'h00, OPC ^ 8'h01}, 8);
    rd(7'h00, d); chk("R9 wrong code rejected", d, e);
    ser_send({8'h00, 8'hFA}, 8);
    rd(7'h00, d); chk("R9 reversed order rejected", d, e);
    gpio_en = 1'b0;
    ser_send({8'h00, OPC}, 8);
    rd(7'h00, d); chk("R9 disabled rejected", d, e);
    gpio_en = 1'b1;
    ser_send({8'h00, OPC}, 8);
    rd(7'h00, d); chk("R9 byte frame resets", d, 7'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule